// File: doc/BRIEF.md
# Sequential Port Address Pointer

This block is the clocked address and control logic for the streaming side of a dual-ported buffer memory. Every rising clock edge samples the port controls: chip enable, read/write, output enable, count enable, pointer load, the two start jumps and the data bus. From them it moves a 13-bit address pointer. The pointer can step by one, take a value from the data bus one cycle after the load was seen, or jump to one of two programmed start addresses.

Two programmed end addresses are compared against the pointer. Each comparison drives its own sticky, active-low end-of-buffer flag. A flag goes low only when an increment lands on its end address. It is released by a clear request or by reset.

The block also issues registered read and write strobes to the memory array, at the address the pointer held when the access was sampled. When the chip enable is sampled high, it reports a power-down state.

Start and end addresses are written through a small configuration input, and the flag clears arrive as a two-bit request. Both come from the control register that sits beside this block.

Top module: `seqp_addr_ptr`

## Requirements
- R1: An active-low asynchronous reset sets the following state: the pointer to 0, both end-of-buffer flags high, the error flag low, both memory strobes low and power-down high. It also sets both start addresses to 0 and both end addresses to 8191.
- R2: When count enable is sampled low and nothing of higher priority applies, the pointer advances by one, wrapping from 8191 to 0. This happens whatever the chip enable level.
- R3: When load is sampled low, data bits 12..0 are captured. At the next rising edge the pointer takes that value, overriding jumps and increment at that edge. The pointer is not changed by the load edge itself, beyond what the other inputs do there.
- R4: A low jump-1 input loads start address 1 into the pointer at that edge, and a low jump-2 input loads start address 2. Jump-1 beats jump-2, and either jump beats the increment.
- R5: A jump sampled while load is low, or in the edge right after a load, is ignored. It sets a sticky error output that only reset clears.
- R6: End flag k (bit k-1 of `eob_n`) goes low at the edge where an increment makes the pointer equal to end address k. The two flags are independent.
- R7: A load or a jump that lands on an end address leaves the flags unchanged.
- R8: A low flag stays low until an edge with its clear bit high (`flag_clr[k-1]`). If an increment match and a clear hit the same flag at one edge, the match wins.
- R9: `cfg_we` high at an edge writes `cfg_data` to the register chosen by `cfg_sel`: 0 for start 1, 1 for start 2, 2 for end 1, 3 for end 2. The new value is used from the next edge on.
- R10: After an edge with chip enable and read/write both low, `mem_wr` is high for one cycle. `mem_addr` is the pointer value before that edge and `mem_wdata` is the sampled data.
- R11: After an edge with chip enable low, read/write high and output enable low, `mem_rd` is high. With output enable high, no read is issued.
- R12: After an edge with chip enable high, `pwr_down` is high and neither strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Port chip enable, active low |
| wr_n | input | 1 | Low selects write, high selects read |
| oe_n | input | 1 | Output enable, active low, needed for reads |
| cnt_n | input | 1 | Count enable, active low |
| load_n | input | 1 | Pointer load from data bus, active low |
| jmp1_n | input | 1 | Jump to start address 1, active low |
| jmp2_n | input | 1 | Jump to start address 2, active low |
| din | input | 16 | Port data bus |
| cfg_we | input | 1 | Write strobe for start/end registers |
| cfg_sel | input | 2 | Register select: 0 start1, 1 start2, 2 end1, 3 end2 |
| cfg_data | input | 13 | Value written to the selected register |
| flag_clr | input | 2 | Clear requests for end flags 1 and 2 |
| ptr | output | 13 | Current address pointer |
| eob_n | output | 2 | End-of-buffer flags, active low, bit 0 is flag 1 |
| seq_err | output | 1 | Sticky error for an illegal jump |
| mem_rd | output | 1 | Registered read strobe to the array |
| mem_wr | output | 1 | Registered write strobe to the array |
| mem_addr | output | 13 | Array address for the strobe |
| mem_wdata | output | 16 | Write data for the array |
| pwr_down | output | 1 | Port sampled disabled |

## Verification
The assertions take for granted that every input is a known 0 or 1 at each rising edge, and that reset is only applied from the clock's falling edge. They need no promise that the load and jump rule is kept, because breaking it is defined behaviour under R5. The random stimulus keeps jumps away from a load and from the edge after it most of the time, and lets a violation through about one time in sixteen. End registers are written with values a few steps ahead of the pointer, so increment matches really occur. The directed part steers loads onto end addresses and a clear onto the same edge as a match.

// File: rtl/seqp_pkg.sv
package seqp_pkg;

  localparam int NBANK = 2;

  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_LOAD = 3'd1,
    SRC_JMP1 = 3'd2,
    SRC_JMP2 = 3'd3,
    SRC_INC  = 3'd4
  } ptr_src_e;

  typedef enum logic [1:0] {
    CFG_START1 = 2'd0,
    CFG_START2 = 2'd1,
    CFG_END1   = 2'd2,
    CFG_END2   = 2'd3
  } cfg_tgt_e;

endpackage

// File: rtl/seqp_regs.sv
module seqp_regs
  import seqp_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [AW-1:0]              cfg_data,
  output logic [NBANK-1:0][AW-1:0]   start_addr,
  output logic [NBANK-1:0][AW-1:0]   end_addr
);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [AW-1:0] start_q;
    logic [AW-1:0] end_q;
    logic          hit_start;
    logic          hit_end;

    assign hit_start = cfg_we && (cfg_sel == 2'(g));
    assign hit_end   = cfg_we && (cfg_sel == 2'(g + NBANK));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= '0;
        end_q   <= '1;
      end else begin
        if (hit_start) start_q <= cfg_data;
        if (hit_end)   end_q   <= cfg_data;
      end
    end

    assign start_addr[g] = start_q;
    assign end_addr[g]   = end_q;
  end

endmodule

// File: rtl/seqp_ptr.sv
module seqp_ptr
  import seqp_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cnt_n,
  input  logic                     load_n,
  input  logic                     jmp1_n,
  input  logic                     jmp2_n,
  input  logic [AW-1:0]            load_data,
  input  logic [NBANK-1:0][AW-1:0] start_addr,
  output logic [AW-1:0]            ptr_q,
  output logic [AW-1:0]            ptr_nxt,
  output logic                     inc_evt,
  output logic                     seq_err
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + ONE;
  endfunction

  logic [AW-1:0] hold_q;
  logic          pend_q;
  logic          err_q;
  logic          jmp_block;
  logic          jmp1_ok;
  logic          jmp2_ok;
  logic          jmp_bad;
  ptr_src_e      src;

  assign jmp_block = !load_n || pend_q;
  assign jmp1_ok   = !jmp1_n && !jmp_block;
  assign jmp2_ok   = !jmp2_n && !jmp_block;
  assign jmp_bad   = (!jmp1_n || !jmp2_n) && jmp_block;

  always_comb begin
    src = SRC_HOLD;
    if (pend_q)       src = SRC_LOAD;
    else if (jmp1_ok) src = SRC_JMP1;
    else if (jmp2_ok) src = SRC_JMP2;
    else if (!cnt_n)  src = SRC_INC;
  end

  always_comb begin
    case (src)
      SRC_LOAD: ptr_nxt = hold_q;
      SRC_JMP1: ptr_nxt = start_addr[0];
      SRC_JMP2: ptr_nxt = start_addr[1];
      SRC_INC:  ptr_nxt = step_addr(ptr_q);
      default:  ptr_nxt = ptr_q;
    endcase
  end

  assign inc_evt = (src == SRC_INC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_nxt;
      pend_q <= !load_n;
      if (!load_n) hold_q <= load_data;
      if (jmp_bad) err_q <= 1'b1;
    end
  end

  assign seq_err = err_q;

endmodule

// File: rtl/seqp_flags.sv
module seqp_flags
  import seqp_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inc_evt,
  input  logic [AW-1:0]            ptr_nxt,
  input  logic [NBANK-1:0][AW-1:0] end_addr,
  input  logic [NBANK-1:0]         flag_clr,
  output logic [NBANK-1:0]         eob_n
);

  function automatic logic addr_match(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a ^ b) == '0;
  endfunction

  for (genvar g = 0; g < NBANK; g++) begin : g_flag
    logic hit;
    logic flag_q;

    assign hit = inc_evt && addr_match(ptr_nxt, end_addr[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q <= 1'b1;
      else if (hit)         flag_q <= 1'b0;
      else if (flag_clr[g]) flag_q <= 1'b1;
    end

    assign eob_n[g] = flag_q;
  end

endmodule

// File: rtl/seqp_strobe.sv
module seqp_strobe #(
  parameter int AW = 13,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic [AW-1:0] ptr_q,
  input  logic [DW-1:0] din,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          pwr_down
);

  logic rd_req;
  logic wr_req;

  assign wr_req = !ce_n && !wr_n;
  assign rd_req = !ce_n && wr_n && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      pwr_down  <= 1'b1;
    end else begin
      mem_rd    <= rd_req;
      mem_wr    <= wr_req;
      mem_addr  <= ptr_q;
      mem_wdata <= din;
      pwr_down  <= ce_n;
    end
  end

endmodule

// File: rtl/seqp_addr_ptr.sv
module seqp_addr_ptr
  import seqp_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             wr_n,
  input  logic             oe_n,
  input  logic             cnt_n,
  input  logic             load_n,
  input  logic             jmp1_n,
  input  logic             jmp2_n,
  input  logic [DW-1:0]    din,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_data,
  input  logic [NBANK-1:0] flag_clr,
  output logic [AW-1:0]    ptr,
  output logic [NBANK-1:0] eob_n,
  output logic             seq_err,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             pwr_down
);

  logic [NBANK-1:0][AW-1:0] start_addr;
  logic [NBANK-1:0][AW-1:0] end_addr;
  logic [AW-1:0]            ptr_nxt;
  logic                     inc_evt;

  seqp_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_data   (cfg_data),
    .start_addr (start_addr),
    .end_addr   (end_addr)
  );

  seqp_ptr #(.AW(AW)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_n      (cnt_n),
    .load_n     (load_n),
    .jmp1_n     (jmp1_n),
    .jmp2_n     (jmp2_n),
    .load_data  (din[AW-1:0]),
    .start_addr (start_addr),
    .ptr_q      (ptr),
    .ptr_nxt    (ptr_nxt),
    .inc_evt    (inc_evt),
    .seq_err    (seq_err)
  );

  seqp_flags #(.AW(AW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_evt  (inc_evt),
    .ptr_nxt  (ptr_nxt),
    .end_addr (end_addr),
    .flag_clr (flag_clr),
    .eob_n    (eob_n)
  );

  seqp_strobe #(.AW(AW), .DW(DW)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .ptr_q     (ptr),
    .din       (din),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pwr_down  (pwr_down)
  );

endmodule

// File: rtl/seqp_addr_ptr_chk.sv
module seqp_addr_ptr_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          wr_n,
  input logic          load_n,
  input logic          jmp1_n,
  input logic [AW-1:0] load_data,
  input logic [1:0]    flag_clr,
  input logic [AW-1:0] ptr,
  input logic          inc_evt,
  input logic [1:0]    eob_n,
  input logic          seq_err,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          pwr_down
);

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> (ptr == AW'($past(ptr) + 1'b1)));

  a_r3_load_one_late: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> ##1 (ptr == $past(load_data, 2)));

  a_r5_bad_jump_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !jmp1_n) |=> seq_err);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  a_r6_flag1_needs_inc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eob_n[0]) |-> $past(inc_evt));

  a_r6_flag2_needs_inc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eob_n[1]) |-> $past(inc_evt));

  a_r8_flag1_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!eob_n[0] && !flag_clr[0]) |=> !eob_n[0]);

  a_r10_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !wr_n) |=> (mem_wr && (mem_addr == $past(ptr))));

  a_r12_idle_when_down: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!mem_rd && !mem_wr));

endmodule

bind seqp_addr_ptr seqp_addr_ptr_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .wr_n      (wr_n),
  .load_n    (load_n),
  .jmp1_n    (jmp1_n),
  .load_data (din[AW-1:0]),
  .flag_clr  (flag_clr),
  .ptr       (ptr),
  .inc_evt   (inc_evt),
  .eob_n     (eob_n),
  .seq_err   (seq_err),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .pwr_down  (pwr_down)
);

// File: tb/tb_seqp_addr_ptr.sv
`timescale 1ns/1ps
module tb_seqp_addr_ptr;
  localparam int AW = 13;
  localparam int DW = 16;
  localparam logic [AW-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ce_n, wr_n, oe_n, cnt_n, load_n, j1_n, j2_n, cfg_we;
  logic [DW-1:0] din;
  logic [1:0]    cfg_sel, clr;
  logic [AW-1:0] cfg_data;

  logic [AW-1:0] ptr, mem_addr;
  logic [1:0]    eob_n;
  logic          seq_err, mem_rd, mem_wr, pwr_down;
  logic [DW-1:0] mem_wdata;

  seqp_addr_ptr #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .oe_n(oe_n),
    .cnt_n(cnt_n), .load_n(load_n), .jmp1_n(j1_n), .jmp2_n(j2_n), .din(din),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .flag_clr(clr),
    .ptr(ptr), .eob_n(eob_n), .seq_err(seq_err), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pwr_down(pwr_down)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  logic [AW-1:0] m_ptr, m_hold, m_addr;
  logic [AW-1:0] m_start [2];
  logic [AW-1:0] m_end [2];
  logic          m_pend, m_err, m_rd, m_wr, m_pd;
  logic [1:0]    m_eob;
  logic [DW-1:0] m_wdata;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    if (a == TOP) return '0;
    return AW'(32'(a) + 32'd1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr = '0; m_hold = '0; m_pend = 1'b0; m_err = 1'b0; m_eob = 2'b11;
    m_rd = 1'b0; m_wr = 1'b0; m_addr = '0; m_wdata = '0; m_pd = 1'b1;
    for (int i = 0; i < 2; i++) begin m_start[i] = '0; m_end[i] = TOP; end
  endtask

  task automatic model_step();
    logic blocked, take_load;
    logic [AW-1:0] nxt;
    logic stepped;
    blocked   = !load_n || m_pend;
    take_load = m_pend;
    stepped   = 1'b0;
    nxt       = m_ptr;
    if (take_load)                nxt = m_hold;
    else if (!j1_n && !blocked)   nxt = m_start[0];
    else if (!j2_n && !blocked)   nxt = m_start[1];
    else if (!cnt_n) begin        nxt = bump(m_ptr); stepped = 1'b1; end
    for (int i = 0; i < 2; i++) begin
      if (stepped && nxt == m_end[i]) m_eob[i] = 1'b0;
      else if (clr[i])                m_eob[i] = 1'b1;
    end
    if ((!j1_n || !j2_n) && blocked) m_err = 1'b1;
    m_wr = !ce_n && !wr_n;
    m_rd = !ce_n && wr_n && !oe_n;
    m_pd = ce_n;
    m_addr = m_ptr;
    m_wdata = din;
    if (!load_n) m_hold = din[AW-1:0];
    m_pend = !load_n;
    m_ptr = nxt;
    if (cfg_we) begin
      if (cfg_sel[1]) m_end[cfg_sel[0]] = cfg_data;
      else            m_start[cfg_sel[0]] = cfg_data;
    end
  endtask

  task automatic cmp_all();
    chk("R2 ptr", 32'(ptr), 32'(m_ptr));
    chk("R6 eob_n", 32'(eob_n), 32'(m_eob));
    chk("R5 seq_err", 32'(seq_err), 32'(m_err));
    chk("R10 mem_wr", 32'(mem_wr), 32'(m_wr));
    chk("R10 mem_addr", 32'(mem_addr), 32'(m_addr));
    chk("R10 mem_wdata", 32'(mem_wdata), 32'(m_wdata));
    chk("R11 mem_rd", 32'(mem_rd), 32'(m_rd));
    chk("R12 pwr_down", 32'(pwr_down), 32'(m_pd));
  endtask

  task automatic idle();
    ce_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1; cnt_n = 1'b1; load_n = 1'b1;
    j1_n = 1'b1; j2_n = 1'b1; din = '0; cfg_we = 1'b0; cfg_sel = '0;
    cfg_data = '0; clr = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp_all();
    idle();
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    tick();
  endtask

  task automatic load(input logic [AW-1:0] val);
    load_n = 1'b0; din = DW'(val);
    tick();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic rand_inputs();
    ce_n   = ($urandom % 10) < 3;
    wr_n   = 1'($urandom);
    oe_n   = ($urandom % 4) == 0;
    cnt_n  = ($urandom % 10) < 3;
    load_n = ($urandom % 12) != 0;
    j1_n   = ($urandom % 10) != 0;
    j2_n   = ($urandom % 10) != 0;
    if ((!load_n || m_pend) && ($urandom % 16) != 0) begin
      j1_n = 1'b1; j2_n = 1'b1;
    end
    din      = DW'($urandom);
    cfg_we   = ($urandom % 16) == 0;
    cfg_sel  = 2'($urandom);
    cfg_data = AW'(32'(m_ptr) + ($urandom % 24));
    clr      = (($urandom % 12) == 0) ? 2'($urandom) : 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", 32'(ptr), 0);
    chk("R1 eob_n", 32'(eob_n), 3);
    chk("R1 err", 32'(seq_err), 0);
    chk("R1 strobes", 32'({mem_rd, mem_wr}), 0);
    chk("R1 pwr_down", 32'(pwr_down), 1);
    rst_n = 1'b1;
    tick();
    // R1: default end address 8191 is not matched by a few steps from 0
    cnt_n = 1'b0; tick();
    chk("R1 end default", 32'(eob_n), 3);

    // R9 program registers
    cfg(2'd0, 13'h0100);
    cfg(2'd1, 13'h0200);
    cfg(2'd2, 13'h0105);
    cfg(2'd3, 13'h0207);

    // R4 jump 1, R9 value used
    j1_n = 1'b0; cnt_n = 1'b0; tick();
    chk("R4 jump1", 32'(ptr), 32'h100);

    // R6 increments to end 1
    for (int i = 0; i < 4; i++) begin cnt_n = 1'b0; tick(); end
    chk("R6 before match", 32'(eob_n), 3);
    cnt_n = 1'b0; tick();
    chk("R6 match end1", 32'(eob_n), 2);
    chk("R6 ptr", 32'(ptr), 32'h105);

    // R8 hold then clear
    tick();
    chk("R8 held low", 32'(eob_n), 2);
    clr = 2'b01; tick();
    chk("R8 cleared", 32'(eob_n), 3);

    // R3 load one cycle late, R7 landing on end address
    j2_n = 1'b0; tick();
    chk("R4 jump2", 32'(ptr), 32'h200);
    load(13'h0105);
    chk("R3 not yet", 32'(ptr), 32'h200);
    tick();
    chk("R3 applied", 32'(ptr), 32'h105);
    chk("R7 no flag", 32'(eob_n), 3);

    // R3 load beats increment
    cnt_n = 1'b0; load_n = 1'b0; din = 16'h0AAA; tick();
    chk("R3 inc on load edge", 32'(ptr), 32'h106);
    cnt_n = 1'b0; tick();
    chk("R3 over inc", 32'(ptr), 32'hAAA);

    // R4 priority
    j1_n = 1'b0; j2_n = 1'b0; cnt_n = 1'b0; tick();
    chk("R4 jump1 first", 32'(ptr), 32'h100);

    // R5 jump during load ignored
    load_n = 1'b0; j1_n = 1'b0; din = 16'h0033; tick();
    chk("R5 ignored", 32'(ptr), 32'h100);
    chk("R5 err set", 32'(seq_err), 1);
    tick();
    chk("R5 load still lands", 32'(ptr), 32'h033);

    // R2 wrap with chip enable high
    load(13'h1FFE);
    tick();
    cnt_n = 1'b0; tick();
    chk("R2 top", 32'(ptr), 32'h1FFF);
    cnt_n = 1'b0; tick();
    chk("R2 wrap", 32'(ptr), 0);

    // R8 set beats clear
    load(13'h0206);
    tick();
    cnt_n = 1'b0; clr = 2'b10; tick();
    chk("R8 set wins", 32'(eob_n), 1);

    // R10 write
    ce_n = 1'b0; wr_n = 1'b0; din = 16'hBEEF; cnt_n = 1'b0; tick();
    chk("R10 wr", 32'({mem_wr, mem_rd}), 2);
    chk("R10 addr", 32'(mem_addr), 32'h207);
    chk("R10 data", 32'(mem_wdata), 32'hBEEF);

    // R11 read
    ce_n = 1'b0; wr_n = 1'b1; oe_n = 1'b0; tick();
    chk("R11 rd", 32'({mem_wr, mem_rd}), 1);
    chk("R11 addr", 32'(mem_addr), 32'h208);
    ce_n = 1'b0; wr_n = 1'b1; oe_n = 1'b1; tick();
    chk("R11 no oe", 32'(mem_rd), 0);

    // R12 power down
    ce_n = 1'b1; wr_n = 1'b0; oe_n = 1'b0; tick();
    chk("R12 down", 32'({pwr_down, mem_wr, mem_rd}), 4);

    // R1 asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #1;
    chk("R1 async ptr", 32'(ptr), 0);
    chk("R1 async eob", 32'(eob_n), 3);
    chk("R1 async err", 32'(seq_err), 0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      rand_inputs();
      tick();
    end

    report();
    $finish;
  end

endmodule